// File: doc/BRIEF.md
# Stop/Go Link Receive Buffer

This block sits at the receiving end of a pipelined point-to-point link whose flow control is a single hold/resume level instead of credits. The far end launches one phit per cycle while it believes it may send; each phit spends a fixed number of cycles on the wire before it shows up here as `rx_valid`/`rx_phit`. The block stores arriving phits in a RAM-backed queue and hands them to a local consumer over a ready/valid handshake. It raises a hold request when the number of free slots drops to a reserve.

The hold request leaves the block twice. `hold_req` is the registered decision at the receiver. `hold_far` is the same level after a delay line of `WIRE_CYC` registers, which stands for the return wire. The reserve is `2*WIRE_CYC + FC_CYC` slots. That covers the phits already on the forward wire when the decision is made, the phits launched while the hold travels back, and the phits the sender launches during its own reaction latency. A sender that stops within `FC_CYC` cycles of seeing `hold_far` therefore never finds the queue full. A hysteresis band of `HYST` slots keeps the hold level from toggling on every phit.

Top module: `onoff_link_rx`

## Requirements
- R1: In the first cycle after synchronous reset is released, `deq_valid`, `hold_req` and `hold_far` are all 0 and the queue holds no phits.
- R2: Phits leave on `deq_phit` in exactly the order in which they were accepted on `rx_phit`, with none duplicated or skipped.
- R3: If a sender stops launching no later than `FC_CYC` cycles after it sees `hold_far` high, and its phits reach `rx_valid` `WIRE_CYC` cycles after launch, then `rx_valid` is never high while all `DEPTH` slots are occupied, and every launched phit is delivered.
- R4: `hold_req` is 1 in every cycle in which the free slot count (`DEPTH` minus phits accepted and not yet dequeued, counted after the clock edge) is at most RESERVE = 2*WIRE_CYC + FC_CYC.
- R5: `hold_req` is 0 whenever the free slot count exceeds RESERVE + HYST (HYST = 2). Inside the band RESERVE < free <= RESERVE + HYST it keeps its previous value, in both directions.
- R6: `hold_far` equals `hold_req` delayed by exactly `WIRE_CYC` clock cycles.
- R7: A phit presented in cycle n to an empty queue with `deq_ready` high appears with `deq_valid` high in cycle n+2, and is gone in cycle n+3.
- R8: While `deq_valid` is 1 and `deq_ready` is 0, `deq_valid` stays 1 and `deq_phit` keeps its value in the next cycle.
- R9: With `deq_ready` held high, a continuous run of phits is passed through at one phit per cycle with no gap, and `hold_req` stays 0.
- R10: `rx_phit` has no effect while `rx_valid` is 0: no phit is stored and nothing appears on `deq_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A phit is arriving from the wire this cycle |
| rx_phit | input | DATA_W | Arriving phit |
| deq_valid | output | 1 | Head phit available to the consumer |
| deq_ready | input | 1 | Consumer takes the head phit this cycle |
| deq_phit | output | DATA_W | Head phit |
| hold_req | output | 1 | Registered hold decision at the receiver |
| hold_far | output | 1 | Hold level as it arrives at the sender end of the return wire |

## Verification
The properties take for granted that whatever drives `rx_valid` obeys the hold within the modelled window: `hold_far` delay plus at most `FC_CYC` cycles of reaction plus `WIRE_CYC` cycles of forward wire. Only under that assumption can the no-overflow property hold. The bench's sender model has exactly that worst-case timing. It keeps sending at full rate until its reaction counter expires and then pushes its phits through a forward pipe of `WIRE_CYC` stages, while consumer patterns that are slow or stall for long periods force repeated hold episodes. The directed threshold tests drive `rx_valid` by hand and never exceed the free space that the test has just counted.

// File: rtl/onoff_link_pkg.sv
package onoff_link_pkg;

  // Slots that must stay free when the hold decision is taken:
  // forward wire contents, phits launched while the hold travels back,
  // and phits launched during the sender's reaction time.
  function automatic int reserve_slots(input int wire_cyc, input int fc_cyc);
    return 2 * wire_cyc + fc_cyc;
  endfunction

  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  typedef enum logic {
    LINK_GO   = 1'b0,
    LINK_HOLD = 1'b1
  } link_ctl_e;

endpackage

// File: rtl/olr_store.sv
// Simple dual-port storage: one write port, one registered read port.
module olr_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/olr_read_ctrl.sv
// Pointer management and the registered output stage of the queue.
module olr_read_ctrl #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int CNT_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          deq_ready,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_en,
  output logic          deq_valid,
  output logic          pop
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [CNT_W-1:0] unread_q;
  logic [CNT_W-1:0] unread_d;
  logic             out_full_q;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return (a == LAST_ADDR) ? '0 : a + AW'(1);
  endfunction

  assign pop   = out_full_q & deq_ready;
  assign rd_en = (unread_q != '0) & (~out_full_q | deq_ready);

  always_comb begin
    unread_d = unread_q;
    if (wr_en && !rd_en) begin
      unread_d = unread_q + CNT_W'(1);
    end else if (!wr_en && rd_en) begin
      unread_d = unread_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr    <= '0;
      rd_addr    <= '0;
      unread_q   <= '0;
      out_full_q <= 1'b0;
    end else begin
      unread_q <= unread_d;
      if (wr_en) begin
        wr_addr <= next_addr(wr_addr);
      end
      if (rd_en) begin
        rd_addr    <= next_addr(rd_addr);
        out_full_q <= 1'b1;
      end else if (pop) begin
        out_full_q <= 1'b0;
      end
    end
  end

  assign deq_valid = out_full_q;

endmodule

// File: rtl/olr_hold_gen.sv
// Occupancy tracking and the hysteretic hold decision.
module olr_hold_gen #(
  parameter int DEPTH   = 32,
  parameter int RESERVE = 8,
  parameter int HYST    = 2,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             pop,
  output logic [CNT_W-1:0] occ,
  output logic             hold
);

  import onoff_link_pkg::*;

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ON_AT   = CNT_W'(RESERVE);
  localparam logic [CNT_W-1:0] OFF_ABV = CNT_W'(RESERVE + HYST);

  logic [CNT_W-1:0] occ_d;
  logic [CNT_W-1:0] free_d;
  link_ctl_e        ctl_q;
  link_ctl_e        ctl_d;

  always_comb begin
    occ_d = occ;
    if (wr_en && !pop) begin
      occ_d = occ + CNT_W'(1);
    end else if (!wr_en && pop) begin
      occ_d = occ - CNT_W'(1);
    end
  end

  assign free_d = DEPTH_C - occ_d;

  always_comb begin
    ctl_d = ctl_q;
    if (free_d <= ON_AT) begin
      ctl_d = LINK_HOLD;
    end else if (free_d > OFF_ABV) begin
      ctl_d = LINK_GO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ   <= '0;
      ctl_q <= LINK_GO;
    end else begin
      occ   <= occ_d;
      ctl_q <= ctl_d;
    end
  end

  assign hold = (ctl_q == LINK_HOLD);

endmodule

// File: rtl/olr_return_line.sv
// Register chain standing in for the return wire.
module olr_return_line #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_wire
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < STAGES; i++) begin
            sr[i] <= sr[i-1];
          end
        end
      end
      assign q = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/onoff_link_rx.sv
module onoff_link_rx #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 32,
  parameter int WIRE_CYC = 3,
  parameter int FC_CYC   = 2,
  parameter int HYST     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_phit,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [DATA_W-1:0] deq_phit,
  output logic              hold_req,
  output logic              hold_far
);

  import onoff_link_pkg::*;

  localparam int RESERVE = reserve_slots(WIRE_CYC, FC_CYC);
  localparam int AW      = addr_bits(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] occ;
  logic             wr_en;
  logic             rd_en;
  logic             pop;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    rd_addr;

  // A phit offered with no room left is discarded rather than corrupting
  // stored data; the checker treats that case as a protocol violation.
  assign wr_en = rx_valid & (occ != DEPTH_C);

  olr_read_ctrl #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .CNT_W (CNT_W)
  ) u_rdctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .deq_ready (deq_ready),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .rd_en     (rd_en),
    .deq_valid (deq_valid),
    .pop       (pop)
  );

  olr_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .AW     (AW)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (rx_phit),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_q    (deq_phit)
  );

  olr_hold_gen #(
    .DEPTH   (DEPTH),
    .RESERVE (RESERVE),
    .HYST    (HYST),
    .CNT_W   (CNT_W)
  ) u_hold (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .pop   (pop),
    .occ   (occ),
    .hold  (hold_req)
  );

  olr_return_line #(
    .STAGES (WIRE_CYC)
  ) u_ret (
    .clk (clk),
    .rst (rst),
    .d   (hold_req),
    .q   (hold_far)
  );

endmodule

// File: rtl/onoff_link_rx_chk.sv
module onoff_link_rx_chk #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 32,
  parameter int RESERVE = 8,
  parameter int HYST    = 2,
  parameter int CNT_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              deq_valid,
  input logic              deq_ready,
  input logic [DATA_W-1:0] deq_phit,
  input logic              hold_req,
  input logic [CNT_W-1:0]  occ
);

  int free_c;
  assign free_c = DEPTH - int'(occ);

  // R3: a correctly paced sender never offers a phit into a full queue
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (int'(occ) < DEPTH));

  // R3: occupancy stays within the storage
  p_occ_range_r3: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);

  // R4: hold whenever free space is at or below the reserve
  p_hold_on_r4: assert property (@(posedge clk) disable iff (rst)
    (free_c <= RESERVE) |-> hold_req);

  // R5: release above the hysteresis band
  p_hold_off_r5: assert property (@(posedge clk) disable iff (rst)
    (free_c > RESERVE + HYST) |-> !hold_req);

  // R5: inside the band the level does not move
  p_band_keep_r5: assert property (@(posedge clk) disable iff (rst)
    ((free_c > RESERVE) && (free_c <= RESERVE + HYST)) |-> $stable(hold_req));

  // R8: a stalled head phit is held
  p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_phit)));

endmodule

bind onoff_link_rx onoff_link_rx_chk #(
  .DATA_W  (DATA_W),
  .DEPTH   (DEPTH),
  .RESERVE (RESERVE),
  .HYST    (HYST),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .deq_valid (deq_valid),
  .deq_ready (deq_ready),
  .deq_phit  (deq_phit),
  .hold_req  (hold_req),
  .occ       (occ)
);

// File: tb/tb_onoff_link_rx.sv
`timescale 1ns/1ps
module tb_onoff_link_rx;

  localparam int DW  = 16;
  localparam int DP  = 32;
  localparam int WC  = 3;
  localparam int FC  = 2;
  localparam int HY  = 2;
  localparam int RES = 2 * WC + FC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_phit = '0;
  logic          deq_valid;
  logic          deq_ready = 1'b0;
  logic [DW-1:0] deq_phit;
  logic          hold_req;
  logic          hold_far;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  onoff_link_rx #(
    .DATA_W (DW), .DEPTH (DP), .WIRE_CYC (WC), .FC_CYC (FC), .HYST (HY)
  ) dut (
    .clk (clk), .rst (rst),
    .rx_valid (rx_valid), .rx_phit (rx_phit),
    .deq_valid (deq_valid), .deq_ready (deq_ready), .deq_phit (deq_phit),
    .hold_req (hold_req), .hold_far (hold_far)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_valid = 1'b0; deq_ready = 1'b0; rx_phit = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // R1: state right after reset
  task automatic t_reset();
    do_reset();
    chk(deq_valid == 1'b0, "R1 deq_valid", deq_valid, 0);
    chk(hold_req == 1'b0, "R1 hold_req", hold_req, 0);
    chk(hold_far == 1'b0, "R1 hold_far", hold_far, 0);
  endtask

  // R7 latency, R10 ignored data while not valid
  task automatic t_latency();
    do_reset();
    deq_ready = 1'b1;
    rx_valid = 1'b1; rx_phit = 16'h00A5;
    @(negedge clk);
    rx_valid = 1'b0; rx_phit = 16'hFFFF;
    chk(deq_valid == 1'b0, "R7 not yet at n+1", deq_valid, 0);
    @(negedge clk);
    chk(deq_valid == 1'b1, "R7 valid at n+2", deq_valid, 1);
    chk(deq_phit == 16'h00A5, "R7 data at n+2", deq_phit, 16'h00A5);
    @(negedge clk);
    chk(deq_valid == 1'b0, "R7 gone at n+3", deq_valid, 0);
    for (int i = 0; i < 6; i++) begin
      rx_phit = DW'(16'h1234 + i);
      @(negedge clk);
      chk(deq_valid == 1'b0, "R10 no phit from idle data", deq_valid, 0);
    end
    chk(hold_req == 1'b0, "R10 hold stays low", hold_req, 0);
  endtask

  // R8 stalled head held, R2 order
  task automatic t_head_hold();
    do_reset();
    rx_valid = 1'b1; rx_phit = 16'd11;
    @(negedge clk);
    rx_phit = 16'd22;
    @(negedge clk);
    rx_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(deq_valid == 1'b1, "R8 valid held", deq_valid, 1);
      chk(deq_phit == 16'd11, "R8 data held", deq_phit, 11);
    end
    deq_ready = 1'b1;
    @(negedge clk);
    chk(deq_phit == 16'd22, "R2 second phit follows", deq_phit, 22);
    @(negedge clk);
    chk(deq_valid == 1'b0, "R2 queue drained", deq_valid, 0);
  endtask

  // R9 full-rate pass-through, R2 order
  task automatic t_stream();
    int rcv = 0;
    int first_c = -1;
    int last_c = -1;
    int bad = 0;
    bit saw_hold = 1'b0;
    do_reset();
    deq_ready = 1'b1;
    for (int c = 0; c < 30; c++) begin
      if (deq_valid) begin
        if (deq_phit != DW'(100 + rcv)) bad++;
        if (first_c < 0) first_c = c;
        last_c = c;
        rcv++;
      end
      if (hold_req) saw_hold = 1'b1;
      rx_valid = (c < 20);
      rx_phit  = DW'(100 + c);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk(rcv == 20, "R9 all phits out", rcv, 20);
    chk(last_c - first_c == 19, "R9 no gaps", last_c - first_c, 19);
    chk(bad == 0, "R2 stream order", bad, 0);
    chk(saw_hold == 1'b0, "R9 no hold", saw_hold, 0);
  endtask

  // R4 threshold, R6 return delay, R5 hysteresis, R2 order
  task automatic t_threshold();
    do_reset();
    for (int i = 0; i < DP - RES; i++) begin
      chk(hold_req == 1'b0, "R4 low above reserve", hold_req, 0);
      rx_valid = 1'b1; rx_phit = DW'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk(hold_req == 1'b1, "R4 high at reserve", hold_req, 1);
    chk(hold_far == 1'b0, "R6 far still low", hold_far, 0);
    for (int k = 1; k <= WC; k++) begin
      @(negedge clk);
      chk(hold_far == (k == WC), "R6 far delay", hold_far, (k == WC));
    end
    for (int p = 1; p <= 4; p++) begin
      deq_ready = 1'b1;
      chk(deq_phit == DW'(p - 1), "R2 order in threshold test", deq_phit, p - 1);
      @(negedge clk);
      deq_ready = 1'b0;
      if (p <= 3) chk(hold_req == (p < 3), "R5 release point", hold_req, (p < 3));
      @(negedge clk);
    end
    // free is now RES+4; refill one at a time
    for (int w = 1; w <= 4; w++) begin
      rx_valid = 1'b1; rx_phit = DW'(500 + w);
      @(negedge clk);
      rx_valid = 1'b0;
      chk(hold_req == (w == 4), "R5 band keeps low, R4 re-hold", hold_req, (w == 4));
    end
  endtask

  // R3: sender model with worst-case reaction timing
  task automatic t_sender(input int mode);
    localparam int TOTAL = 400;
    bit            fwv [0:WC];
    logic [DW-1:0] fwd [0:WC];
    bit            hist[0:FC];
    int sent = 0;
    int rcv  = 0;
    int bad  = 0;
    int cyc  = 0;
    bit seen = 1'b0;
    bit launch;
    bit rdy;
    do_reset();
    for (int j = 0; j <= WC; j++) begin fwv[j] = 1'b0; fwd[j] = '0; end
    for (int j = 0; j <= FC; j++) hist[j] = 1'b0;
    while (rcv < TOTAL && cyc < 20000) begin
      cyc++;
      if (mode == 0) rdy = (cyc % 4 == 0);
      else rdy = ((cyc / 50) % 2 == 1) || (sent == TOTAL);
      if (deq_valid && rdy) begin
        if (deq_phit != DW'(rcv)) bad++;
        rcv++;
      end
      deq_ready = rdy;
      if (hold_far) seen = 1'b1;
      for (int j = FC; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = hold_far;
      launch = !hist[FC] && (sent < TOTAL);
      for (int j = WC; j > 0; j--) begin fwv[j] = fwv[j-1]; fwd[j] = fwd[j-1]; end
      fwv[0] = launch;
      fwd[0] = DW'(sent);
      if (launch) sent++;
      rx_valid = fwv[WC];
      rx_phit  = fwd[WC];
      @(negedge clk);
    end
    rx_valid = 1'b0; deq_ready = 1'b0;
    chk(rcv == TOTAL, "R3 every phit delivered", rcv, TOTAL);
    chk(bad == 0, "R3 no phit lost or reordered", bad, 0);
    chk(seen == 1'b1, "R3 hold exercised", seen, 1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_head_hold();
    t_stream();
    t_threshold();
    t_sender(0);
    t_sender(1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule